// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Window

This block lets a host reach a large word-addressed node memory through four host offsets. The block is a slave on the host bus and a master on the node memory bus. The host first loads a word pointer. It then writes or reads a data offset, and each such access becomes one word transaction on the node bus at the pointer.

When the node memory acknowledges a data transaction, the pointer steps to the next word. A block transfer is therefore one pointer load followed by a run of data accesses, with no further address writes. The pointer wraps at the top of the word space. Host accesses that have no memory side complete at once.

The host drives `host_sel` with a stable offset, direction and data. It holds them until it sees `host_rdy` high, and the access finishes at that clock edge.

Top module: `autoinc_window`

## Requirements
- R1: After reset the pointer is zero and no memory request is pending: `mem_req` is low, and reading offset 0 returns 0.
- R2: A host write to offset 0 loads the pointer with the low ADDR_W bits of the written word, discarding the upper bits. It completes in the cycle it is presented and issues no memory request.
- R3: A host read of offset 0 returns the pointer zero-extended to DATA_W bits, and it completes in the cycle it is presented.
- R4: A host write to offset 1 raises `mem_req` one clock edge later, with `mem_we` high, `mem_addr` equal to the pointer and `mem_wdata` equal to the host datum.
- R5: A host read of offset 2 raises `mem_req` one clock edge later with `mem_we` low. In the cycle where `mem_ack` is high, `host_rdata` carries `mem_rdata`.
- R6: During an offset 1 write or an offset 2 read, `host_rdy` stays low until the cycle in which `mem_ack` is high, and it is high in that cycle.
- R7: The pointer increases by one at the clock edge where a data transaction is acknowledged, and at no other time except an offset 0 write.
- R8: Stepping the pointer from all ones gives zero, and no error is flagged.
- R9: A write to offset 2, a read of offset 1, and any access to offset 3 complete in the cycle they are presented. They return 0, issue no memory request and leave the pointer unchanged.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` keep their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access in progress |
| host_off | input | 2 | Host offset: 0 pointer, 1 write data, 2 read data, 3 unused |
| host_we | input | 1 | Host access is a write |
| host_wdata | input | DATA_W | Host write datum |
| host_rdata | output | DATA_W | Host read datum, valid while host_rdy is high |
| host_rdy | output | 1 | Host access completes at this edge |
| mem_req | output | 1 | Node memory transaction pending |
| mem_we | output | 1 | Pending transaction is a write |
| mem_addr | output | ADDR_W | Node word address (the pointer) |
| mem_wdata | output | DATA_W | Node write datum |
| mem_rdata | input | DATA_W | Node read datum, valid with mem_ack |
| mem_ack | input | 1 | Node memory completes the transaction |

## Verification
Pointer accesses and unused accesses must show `host_rdy` in the same cycle they are presented. A data access raises `mem_req` one edge after it is presented. With a memory model that waits L extra cycles before acknowledging, the host therefore sees exactly L+2 falling-edge samples with `host_rdy` low.

The driver counts those stalled samples and compares the count with L+2 for several values of L. The monitor samples returned data on the falling edge where `host_rdy` is high, which is the cycle the acknowledge arrives. The new pointer value is checked by a pointer read issued after the access has completed.

// File: rtl/autoinc_window.sv
module autoinc_window #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic [1:0]        host_off,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam logic [1:0] OFF_PTR = 2'd0;
  localparam logic [1:0] OFF_WR  = 2'd1;
  localparam logic [1:0] OFF_RD  = 2'd2;

  logic [ADDR_W-1:0] ptr;
  logic              busy;

  wire is_wr    = (host_off == OFF_WR) && host_we;
  wire is_rd    = (host_off == OFF_RD) && !host_we;
  wire data_acc = host_sel && (is_wr || is_rd);
  wire ptr_ld   = host_sel && !busy && (host_off == OFF_PTR) && host_we;
  wire ptr_rd   = host_sel && (host_off == OFF_PTR) && !host_we;
  wire done     = busy && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else if (done) begin
      busy <= 1'b0;
      ptr  <= ptr + 1'b1;
    end else if (!busy && data_acc) begin
      busy      <= 1'b1;
      mem_we    <= is_wr;
      mem_wdata <= host_wdata;
    end else if (ptr_ld) begin
      ptr <= host_wdata[ADDR_W-1:0];
    end
  end

  assign mem_req    = busy;
  assign mem_addr   = ptr;
  assign host_rdy   = data_acc ? done : host_sel;
  assign host_rdata = ptr_rd            ? DATA_W'(ptr) :
                      (is_rd && done)   ? mem_rdata    : '0;
endmodule

module autoinc_window_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic [1:0]        host_off,
  input logic              host_we,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_rdy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |-> !host_rdy);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_off == 2'd0 && host_we && !mem_req |=> mem_addr == $past(host_wdata[ADDR_W-1:0]) && !mem_req);
  // R4
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_off == 2'd1 && host_we && !mem_req |=> mem_req && mem_we && mem_wdata == $past(host_wdata));
  // R9
  unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_off == 2'd3 && !mem_req |-> host_rdy && host_rdata == '0);
endmodule

bind autoinc_window autoinc_window_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_off(host_off), .host_we(host_we),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/test_autoinc_window.sv
module test_autoinc_window;
  localparam int AW = 22;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          host_sel = 1'b0;
  logic [1:0]    host_off = '0;
  logic          host_we = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rdy;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  autoinc_window #(.ADDR_W(AW), .DATA_W(DW)) i_autoinc_window (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_off(host_off), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Node memory model with programmable acknowledge latency
  logic [DW-1:0] mdl [int];
  int lat = 0;
  int cnt = 0;
  int mem_done = 0;
  always @(posedge clk) begin
    if (mem_ack) begin
      if (mem_we) mdl[int'(mem_addr)] = mem_wdata;
      mem_ack <= 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : '0;
      end else cnt++;
    end
  end
  always @(negedge clk) if (rst_n && mem_req && mem_ack) mem_done++;

  // Scoreboard
  logic [DW-1:0] exp_q[$];
  bit            cmp_q[$];
  string         tag_q[$];
  logic [DW-1:0] sb_e;
  bit            sb_c;
  string         sb_t;
  always @(negedge clk) begin
    if (rst_n && host_sel && host_rdy) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 completion with no access queued actual=1 expected=0");
      end else begin
        sb_e = exp_q.pop_front();
        sb_c = cmp_q.pop_front();
        sb_t = tag_q.pop_front();
        if (sb_c) check(sb_t, host_rdata, sb_e);
      end
    end
  end

  task automatic host_op(input logic [1:0] off, input logic we, input logic [DW-1:0] d,
                         input bit cmp, input logic [DW-1:0] exp, input string tag,
                         output int stall);
    exp_q.push_back(exp); cmp_q.push_back(cmp); tag_q.push_back(tag);
    @(posedge clk); #1;
    host_sel = 1'b1; host_off = off; host_we = we; host_wdata = d; stall = 0;
    @(negedge clk);
    while (!host_rdy) begin stall++; @(negedge clk); end
    @(posedge clk); #1;
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic wr_ptr(input logic [DW-1:0] a);
    int s;
    host_op(2'd0, 1'b1, a, 1'b0, '0, "R2", s);
    check("R2 pointer load stall", DW'(s), '0);
  endtask

  task automatic rd_ptr(input logic [DW-1:0] exp, input string tag);
    int s;
    host_op(2'd0, 1'b0, '0, 1'b1, exp, tag, s);
    check("R3 pointer read stall", DW'(s), '0);
  endtask

  task automatic wr_data(input logic [DW-1:0] d, input string tag);
    int s;
    host_op(2'd1, 1'b1, d, 1'b0, '0, tag, s);
    check("R6 write stall", DW'(s), DW'(lat + 2));
  endtask

  task automatic rd_data(input logic [DW-1:0] exp, input string tag);
    int s;
    host_op(2'd2, 1'b0, '0, 1'b1, exp, tag, s);
    check("R6 read stall", DW'(s), DW'(lat + 2));
  endtask

  initial begin
    int s, base;
    repeat (3) @(posedge clk);
    #1;
    check("R1 mem_req in reset", DW'(mem_req), '0);
    rst_n = 1'b1;
    rd_ptr('0, "R1 pointer after reset");

    wr_ptr(32'h10);
    rd_ptr(32'h10, "R3 pointer readback");
    wr_ptr(32'hFFC0_0005);
    rd_ptr(32'h5, "R2 upper bits dropped");

    wr_ptr(32'h10);
    lat = 0; wr_data(32'hA1A1_0001, "R4");
    lat = 2; wr_data(32'hB2B2_0002, "R4");
    lat = 5; wr_data(32'hC3C3_0003, "R4"); // R10: request held over five wait cycles
    check("R4 word 0x10", mdl[32'h10], 32'hA1A1_0001);
    check("R4 word 0x11", mdl[32'h11], 32'hB2B2_0002);
    check("R10 word 0x12", mdl[32'h12], 32'hC3C3_0003);
    rd_ptr(32'h13, "R7 after three writes");

    mdl[32'h200] = 32'h1111_2222;
    mdl[32'h201] = 32'h3333_4444;
    mdl[32'h202] = 32'h5555_6666;
    wr_ptr(32'h200);
    lat = 1; rd_data(32'h1111_2222, "R5 read 0x200");
    lat = 0; rd_data(32'h3333_4444, "R5 read 0x201");
    lat = 3; rd_data(32'h5555_6666, "R5 read 0x202");
    rd_ptr(32'h203, "R7 after three reads");

    base = mem_done;
    host_op(2'd3, 1'b0, '0, 1'b1, '0, "R9 read offset 3", s);
    check("R9 offset 3 read stall", DW'(s), '0);
    host_op(2'd3, 1'b1, 32'hDEAD_BEEF, 1'b0, '0, "R9", s);
    host_op(2'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, '0, "R9", s);
    check("R9 write to read port stall", DW'(s), '0);
    host_op(2'd1, 1'b0, '0, 1'b1, '0, "R9 read of write port", s);
    check("R9 memory transactions", DW'(mem_done - base), '0);
    rd_ptr(32'h203, "R9 pointer unchanged");

    mdl[0] = 32'h5A5A_5A5A;
    wr_ptr(32'h3F_FFFF);
    lat = 1; wr_data(32'h0000_ABCD, "R8");
    check("R8 top word written", mdl[32'h3F_FFFF], 32'h0000_ABCD);
    rd_ptr('0, "R8 pointer wrapped");
    rd_data(32'h5A5A_5A5A, "R8 read after wrap");
    rd_ptr(32'h1, "R7 step after wrap");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule